// File: doc/BRIEF.md
# Global-History Correlating Branch Predictor

This block guesses whether a conditional branch will be taken. It keeps a shift register of the directions of the most recently resolved branches. It also keeps a table of saturating counters, organised as rows. A row is chosen by the low-order word-address bits of the branch PC. Inside that row, the current global history value picks one of 2^HIST_BITS counters, and the top bit of that counter is the prediction.

The fetch stage presents a PC on the lookup port and gets a combinational taken/not-taken answer back. When a branch resolves, the execute stage presents its PC and actual direction on the update port with a valid strobe. In that cycle the block steps the selected counter toward the outcome and shifts the outcome into the history. Both changes are visible from the next cycle on.

There is no tag check, so branches whose PCs share the index bits share a row. Setting HIST_BITS to 0 reduces the block to a plain table of 2-bit counters indexed by PC.

Top module: `corr_branch_pred`

## Requirements
- R1: After reset every counter holds 01 (weakly not taken) and the history is zero, so every lookup predicts not taken (lk_taken = 0).
- R2: lk_taken is 1 exactly when the counter selected by the current history, in the row selected by lk_pc, is 2 or 3; the answer is combinational in lk_pc.
- R3: A counter saturates: a taken update at 3 leaves it at 3 and a not-taken update at 0 leaves it at 0.
- R4: A taken update raises the selected counter by one and a not-taken update lowers it by one, so a strongly biased counter changes its prediction only after two opposite outcomes in a row.
- R5: On each valid update the history shifts left by one and the outcome (1 = taken, 0 = not taken) enters at bit 0, with the oldest bit dropped; the counter is chosen with the history as it was before this shift.
- R6: An update changes only the counter picked by the history within the row picked by up_pc; the other counters in that row and all other rows keep their values.
- R7: The row index is PC bits [IDX_W+1:2]; PCs that differ only in bits [1:0] or above bit IDX_W+1 use the same row.
- R8: An update in a cycle affects lookups starting in the next cycle, and lk_taken holds steady while lk_pc is held and no update occurs.
- R9: When up_valid is 0, up_pc and up_taken have no effect on counters or history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lk_pc | input | PC_W | PC of the branch being fetched |
| lk_taken | output | 1 | Predicted direction for lk_pc, 1 = taken |
| up_valid | input | 1 | A branch resolved this cycle |
| up_pc | input | PC_W | PC of the resolved branch |
| up_taken | input | 1 | Actual direction of the resolved branch, 1 = taken |

## Verification
A corrupted history register moves every following lookup onto a different counter. The error shows on lk_taken as soon as the counters of a row differ between history values, which is usually a few updates after the fault. A wrong counter step or a write to the wrong counter stays hidden until that counter crosses the 1/2 boundary, so a fault can take one or two updates of the same branch and history to surface. The bench keeps a full reference copy of the table and history and compares every lookup, so any such divergence is reported within the cycles that first expose it.

// File: rtl/gcp_pkg.sv
package gcp_pkg;
  // Byte-offset bits of a 4-byte instruction address that never vary.
  localparam int unsigned BYTE_OFS = 2;

  // Counter value one step below the taken threshold.
  function automatic int unsigned weak_not_taken(input int unsigned bits);
    return (32'd1 << (bits - 1)) - 32'd1;
  endfunction
endpackage

// File: rtl/gcp_rst_sync.sv
module gcp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/gcp_history.sv
module gcp_history #(
  parameter int unsigned HIST_BITS = 2,
  parameter int unsigned SEL_W     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             bit_in,
  output logic [SEL_W-1:0] hist_o
);
  generate
    if (HIST_BITS == 0) begin : g_none
      logic unused_hist;
      assign unused_hist = ^{clk, rst_n, shift_en, bit_in};
      assign hist_o = '0;
    end else begin : g_shift
      logic [SEL_W-1:0] hist_q;
      logic [SEL_W-1:0] hist_d;

      always_comb begin
        hist_d = SEL_W'({hist_q, bit_in});
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        hist_q <= '0;
        else if (shift_en) hist_q <= hist_d;
      end

      assign hist_o = hist_q;
    end
  endgenerate
endmodule

// File: rtl/gcp_sat_ctr.sv
module gcp_sat_ctr #(
  parameter int unsigned W = 2
) (
  input  logic [W-1:0] cur,
  input  logic         up,
  output logic [W-1:0] nxt
);
  localparam logic [W-1:0] TOP = '1;

  always_comb begin
    if (up) nxt = (cur == TOP) ? cur : cur + W'(1);
    else    nxt = (cur == '0)  ? cur : cur - W'(1);
  end
endmodule

// File: rtl/gcp_table.sv
module gcp_table #(
  parameter int unsigned ROWS     = 1024,
  parameter int unsigned IDX_W    = 10,
  parameter int unsigned SEL_W    = 2,
  parameter int unsigned WAYS     = 4,
  parameter int unsigned CTR_BITS = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [IDX_W-1:0]    rd_row,
  input  logic [SEL_W-1:0]    rd_way,
  output logic [CTR_BITS-1:0] rd_ctr,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_row,
  input  logic [SEL_W-1:0]    wr_way,
  input  logic                wr_taken,
  output logic [CTR_BITS-1:0] upd_old,
  output logic [CTR_BITS-1:0] upd_new
);
  localparam int unsigned ROW_W = WAYS * CTR_BITS;
  localparam logic [CTR_BITS-1:0] CTR_INIT =
    CTR_BITS'(gcp_pkg::weak_not_taken(CTR_BITS));
  localparam logic [ROW_W-1:0] ROW_INIT = {WAYS{CTR_INIT}};

  logic [ROW_W-1:0] rows_q [ROWS];
  logic [ROW_W-1:0] row_cur;
  logic [ROW_W-1:0] row_nxt;

  // Lookup side
  always_comb begin
    rd_ctr = rows_q[rd_row][int'(rd_way)*CTR_BITS +: CTR_BITS];
  end

  // Update side: read-modify-write of one counter
  always_comb begin
    row_cur = rows_q[wr_row];
    upd_old = row_cur[int'(wr_way)*CTR_BITS +: CTR_BITS];
  end

  gcp_sat_ctr #(.W(CTR_BITS)) u_step (
    .cur (upd_old),
    .up  (wr_taken),
    .nxt (upd_new)
  );

  always_comb begin
    row_nxt = row_cur;
    row_nxt[int'(wr_way)*CTR_BITS +: CTR_BITS] = upd_new;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) rows_q[r] <= ROW_INIT;
    end else if (wr_en) begin
      rows_q[wr_row] <= row_nxt;
    end
  end
endmodule

// File: rtl/corr_branch_pred.sv
module corr_branch_pred #(
  parameter int unsigned HIST_BITS = 2,
  parameter int unsigned CTR_BITS  = 2,
  parameter int unsigned ROWS      = 1024,
  parameter int unsigned PC_W      = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_taken,
  input  logic            up_valid,
  input  logic [PC_W-1:0] up_pc,
  input  logic            up_taken
);
  localparam int unsigned IDX_W = $clog2(ROWS);
  localparam int unsigned SEL_W = (HIST_BITS > 0) ? HIST_BITS : 1;
  localparam int unsigned WAYS  = 1 << HIST_BITS;
  localparam int unsigned LO    = gcp_pkg::BYTE_OFS;
  localparam int unsigned HI    = LO + IDX_W - 1;

  logic                rst_n_sync;
  logic [SEL_W-1:0]    hist_q;
  logic [IDX_W-1:0]    lk_row;
  logic [IDX_W-1:0]    up_row;
  logic [CTR_BITS-1:0] lk_ctr;
  logic [CTR_BITS-1:0] upd_old;
  logic [CTR_BITS-1:0] upd_new;
  logic                unused_pc;

  assign lk_row    = lk_pc[HI:LO];
  assign up_row    = up_pc[HI:LO];
  assign unused_pc = ^{lk_pc[PC_W-1:HI+1], lk_pc[LO-1:0],
                       up_pc[PC_W-1:HI+1], up_pc[LO-1:0]};

  gcp_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  gcp_history #(.HIST_BITS(HIST_BITS), .SEL_W(SEL_W)) u_hist (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .shift_en (up_valid),
    .bit_in   (up_taken),
    .hist_o   (hist_q)
  );

  gcp_table #(
    .ROWS(ROWS), .IDX_W(IDX_W), .SEL_W(SEL_W),
    .WAYS(WAYS), .CTR_BITS(CTR_BITS)
  ) u_tab (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .rd_row   (lk_row),
    .rd_way   (hist_q),
    .rd_ctr   (lk_ctr),
    .wr_en    (up_valid),
    .wr_row   (up_row),
    .wr_way   (hist_q),
    .wr_taken (up_taken),
    .upd_old  (upd_old),
    .upd_new  (upd_new)
  );

  assign lk_taken = lk_ctr[CTR_BITS-1];
endmodule

// File: rtl/corr_branch_pred_chk.sv
module corr_branch_pred_chk #(
  parameter int unsigned HIST_BITS = 2,
  parameter int unsigned CTR_BITS  = 2,
  parameter int unsigned PC_W      = 32,
  parameter int unsigned SEL_W     = 2
) (
  input logic                clk,
  input logic                rst_n_sync,
  input logic [PC_W-1:0]     lk_pc,
  input logic                lk_taken,
  input logic                up_valid,
  input logic                up_taken,
  input logic [SEL_W-1:0]    hist_q,
  input logic [CTR_BITS-1:0] upd_old,
  input logic [CTR_BITS-1:0] upd_new
);
  localparam logic [CTR_BITS-1:0] TOP = '1;

  // R3: saturation at both ends
  a_r3_sat_top: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (up_valid && up_taken && upd_old == TOP) |-> upd_new == TOP);
  a_r3_sat_bottom: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (up_valid && !up_taken && upd_old == '0) |-> upd_new == '0);

  // R4: one step per update in the outcome's direction
  a_r4_step_up: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (up_valid && up_taken && upd_old != TOP) |-> upd_new == CTR_BITS'(upd_old + 1'b1));
  a_r4_step_down: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (up_valid && !up_taken && upd_old != '0) |-> upd_new == CTR_BITS'(upd_old - 1'b1));

  // R8: prediction stable with no update and a held PC
  a_r8_pred_stable: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (!up_valid ##1 $stable(lk_pc)) |-> $stable(lk_taken));

  generate
    if (HIST_BITS > 0) begin : g_hist_chk
      // R5: outcome enters at bit 0
      a_r5_hist_shift: assert property (@(posedge clk) disable iff (!rst_n_sync)
        up_valid |=> hist_q == SEL_W'({$past(hist_q), $past(up_taken)}));
      // R9: history untouched without a valid update
      a_r9_hist_hold: assert property (@(posedge clk) disable iff (!rst_n_sync)
        !up_valid |=> $stable(hist_q));
    end
  endgenerate
endmodule

bind corr_branch_pred corr_branch_pred_chk #(
  .HIST_BITS(HIST_BITS), .CTR_BITS(CTR_BITS), .PC_W(PC_W), .SEL_W(SEL_W)
) u_chk (
  .clk        (clk),
  .rst_n_sync (rst_n_sync),
  .lk_pc      (lk_pc),
  .lk_taken   (lk_taken),
  .up_valid   (up_valid),
  .up_taken   (up_taken),
  .hist_q     (hist_q),
  .upd_old    (upd_old),
  .upd_new    (upd_new)
);

// File: tb/corr_branch_pred_bench.sv
module corr_branch_pred_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS = 1024;
  localparam int WAYS = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lk_pc = '0;
  logic        lk_taken;
  logic        up_valid = 1'b0;
  logic [31:0] up_pc = '0;
  logic        up_taken = 1'b0;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  int ref_ctr [ROWS][WAYS];
  int ref_hist;

  always #(CLK_PERIOD/2) clk = ~clk;

  corr_branch_pred u_corr_branch_pred (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken),
    .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken)
  );

  function automatic int row_of(input logic [31:0] pc);
    return int'(pc[11:2]);
  endfunction

  function automatic logic ref_pred(input logic [31:0] pc);
    return ref_ctr[row_of(pc)][ref_hist] >= 2;
  endfunction

  task automatic ref_reset();
    for (int r = 0; r < ROWS; r++)
      for (int w = 0; w < WAYS; w++) ref_ctr[r][w] = 1;
    ref_hist = 0;
  endtask

  task automatic ref_update(input logic [31:0] pc, input logic t);
    int c;
    c = ref_ctr[row_of(pc)][ref_hist];
    if (t && c < 3) c++;
    if (!t && c > 0) c--;
    ref_ctr[row_of(pc)][ref_hist] = c;
    ref_hist = ((ref_hist << 1) | int'(t)) & 3;
  endtask

  task automatic check(input logic act, input logic exp, input string req);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: lk_taken=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // Drive one cycle at the falling edge, check the lookup, then let the edge commit.
  task automatic step(input logic [31:0] lpc, input logic v,
                      input logic [31:0] upc, input logic t, input string req);
    @(negedge clk);
    lk_pc = lpc; up_valid = v; up_pc = upc; up_taken = t;
    #1;
    check(lk_taken, ref_pred(lpc), req);
    @(posedge clk);
    if (v) ref_update(upc, t);
  endtask

  function automatic logic [31:0] rand_pc(input int nrows);
    logic [31:0] p;
    p = $urandom;
    p[11:2] = 10'(($urandom % nrows) * 37);
    return p;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] pa, pb;
    void'($urandom(32'd1234));
    ref_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1: reset state predicts not taken everywhere
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); lk_pc = $urandom; #1;
      check(lk_taken, 1'b0, "R1 reset not taken");
    end

    // R3/R4: drive one branch taken until saturated, then reverse it
    pa = 32'h0000_1230;
    for (int i = 0; i < 6; i++) step(pa, 1'b1, pa, 1'b1, "R4 climb");
    step(pa, 1'b0, pa, 1'b1, "R3 saturated top");
    for (int i = 0; i < 6; i++) step(pa, 1'b1, pa, 1'b0, "R4 descend");
    step(pa, 1'b0, pa, 1'b0, "R3 saturated bottom");

    // R7: aliases differing in high and byte-offset bits share a row
    pb = pa ^ 32'hABC0_0003;
    for (int i = 0; i < 4; i++) step(pb, 1'b1, pa, 1'b1, "R7 alias update");
    step(pb, 1'b0, pa, 1'b0, "R7 alias lookup");

    // R9: invalid updates leave everything alone
    for (int i = 0; i < 6; i++) step(pa, 1'b0, pa, 1'b0, "R9 ignored update");
    for (int i = 0; i < 6; i++) step(pa, 1'b0, rand_pc(16), 1'b1, "R9 ignored update");

    // R5/R6: alternating pattern trains different counters in one row
    for (int i = 0; i < 40; i++) step(pa, 1'b1, pa, i[0], "R5 R6 pattern");

    // R8: same-cycle update seen only on the following lookup
    step(pa, 1'b1, pa, 1'b1, "R8 same cycle");
    step(pa, 1'b0, pa, 1'b0, "R8 next cycle");

    // R2: constrained random over a small set of rows
    for (int i = 0; i < 4000; i++)
      step(rand_pc(12), ($urandom % 4) != 0, rand_pc(12), ($urandom % 3) != 0, "R2 random");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule